// File: doc/BRIEF.md
# Interval Timer with Buffered Compare

This block is a 16-bit up-counter that advances on cycles where a count-clock enable is high. A period register sets the interval: the counter climbs from zero to the programmed value and then clears, so a setting of D gives an interval of D + 1 enabled cycles. Each clear raises a one-cycle period interrupt pulse.

A second register, the match register, is not compared directly. Its value passes into a shadow buffer, and the counter is compared with that buffer. On each equal count, an output pin inverts and a one-cycle match interrupt pulse is raised. When the match register holds the same value as the period register, the pin gives a square wave with a half-period of one interval. When the match channel is not needed, set it to 0xFFFF and mask its interrupt. Both shadow buffers reload while the timer is stopped and each time the counter clears, so a write made in mid-period first takes effect in the next period.

A small register port writes the two compare registers and reads them back together with the live count. A run input starts and stops the timer. Each interrupt has its own mask input, and a mask never alters the output pin.

Top module: `interval_timer`

## Requirements
- R1: After reset, the count reads 0, both compare registers read 0xFFFF, and toggleOut, irqPeriod and irqMatch are all low.
- R2: While run is high, the counter changes only on cycles where cntEn is high. On other cycles it holds its value.
- R3: While running, an enabled cycle whose count equals the period buffer clears the counter to 0. Any other enabled cycle adds one. In the cycle after that clearing edge, irqPeriod is high for exactly one cycle, so the interval is D0 + 1 enabled cycles. A period value of 0 keeps the count at 0 and pulses on every enabled cycle.
- R4: Writes go to register 0 (the period) when wrSel is 0 and to register 1 (the match) when wrSel is 1. Comparisons use the shadow buffers only. The buffers take their register's new value, including a write made in that same cycle, on every cycle with run low and on every clearing edge. A write made in mid-period therefore changes behaviour only from the next period.
- R5: An enabled cycle whose count equals the match buffer inverts toggleOut at that edge. In the cycle after, it raises irqMatch for one cycle.
- R6: With both registers set to the same value D, toggleOut inverts once every D + 1 enabled cycles.
- R7: rdData shows the selected value combinationally: the period register when rdSel is 0, the match register when rdSel is 1, the live count when rdSel is 2, and 0 when rdSel is 3.
- R8: In the cycle after any clock edge at which run is low, the count is 0, toggleOut is low, and both interrupts are low.
- R9: maskPeriod and maskMatch, when high at the event edge, suppress irqPeriod and irqMatch respectively. Counting and toggleOut are not affected.
- R10: With the match register at 0xFFFF and a smaller period, toggleOut and irqMatch never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Timer runs while high; stopped and cleared while low |
| cntEn | input | 1 | Count-clock enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 period, 1 match |
| wrData | input | 16 | Write data |
| rdSel | input | 2 | Read select: 0 period, 1 match, 2 count, 3 zero |
| rdData | output | 16 | Read data |
| maskPeriod | input | 1 | Suppresses irqPeriod |
| maskMatch | input | 1 | Suppresses irqMatch |
| toggleOut | output | 1 | Output that inverts on each match |
| irqPeriod | output | 1 | One-cycle pulse after each counter clear |
| irqMatch | output | 1 | One-cycle pulse after each match |

## Verification
The bench goes after writes made in mid-period. A design that compared the register directly would toggle early, in the current period, and not from the next one. A period value of zero must keep the count pinned at 0 and pulse on every enabled cycle; a design with an off-by-one on the clear would count to 1 or skip pulses. Sparse and random count enables expose a design that counts on idle cycles. Stopping in mid-interval must leave the pin low and the count at zero. Masking must leave the toggle cadence exactly as it was without the mask.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // Control-to-datapath strobes, one set per clock
  typedef struct packed {
    logic idle;   // timer stopped: clear count and pin, reload shadows
    logic inc;    // advance the counter by one
    logic wrap;   // end of period: clear counter, reload shadows
    logic flip;   // invert the toggle output
  } ivtStrobe_t;
endpackage

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ivtStrobe_t       stb,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] countVal,
  output logic             eqPeriod,
  output logic             eqMatch,
  output logic             toggleOut
);
  localparam int NUM_CMP = 2;
  localparam logic [CNT_W-1:0] CMP_RST = '1;

  logic [CNT_W-1:0] cmpReg  [NUM_CMP];
  logic [CNT_W-1:0] cmpNext [NUM_CMP];
  logic [CNT_W-1:0] cmpBuf  [NUM_CMP];
  logic             reload;

  assign reload = stb.idle | stb.wrap;

  for (genvar ch = 0; ch < NUM_CMP; ch++) begin : gCmp
    logic wrHit;
    assign wrHit       = wrEn && (wrSel == 1'(ch));
    assign cmpNext[ch] = wrHit ? wrData : cmpReg[ch];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpReg[ch] <= CMP_RST;
        cmpBuf[ch] <= CMP_RST;
      end else begin
        cmpReg[ch] <= cmpNext[ch];
        if (reload) cmpBuf[ch] <= cmpNext[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal  <= '0;
      toggleOut <= 1'b0;
    end else begin
      if (stb.idle || stb.wrap) countVal <= '0;
      else if (stb.inc)         countVal <= countVal + 1'b1;

      if (stb.idle)      toggleOut <= 1'b0;
      else if (stb.flip) toggleOut <= ~toggleOut;
    end
  end

  assign eqPeriod = (countVal == cmpBuf[0]);
  assign eqMatch  = (countVal == cmpBuf[1]);

  always_comb begin
    unique case (rdSel)
      2'd0:    rdData = cmpReg[0];
      2'd1:    rdData = cmpReg[1];
      2'd2:    rdData = countVal;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       cntEn,
  input  logic       eqPeriod,
  input  logic       eqMatch,
  input  logic       maskPeriod,
  input  logic       maskMatch,
  output ivtStrobe_t stb,
  output logic       irqPeriod,
  output logic       irqMatch
);
  logic tick;

  assign tick     = run && cntEn;
  assign stb.idle = !run;
  assign stb.wrap = tick && eqPeriod;
  assign stb.inc  = tick && !eqPeriod;
  assign stb.flip = tick && eqMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPeriod <= 1'b0;
      irqMatch  <= 1'b0;
    end else begin
      irqPeriod <= stb.wrap && !maskPeriod;
      irqMatch  <= stb.flip && !maskMatch;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic        cntEn,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [15:0] wrData,
  input  logic [1:0]  rdSel,
  output logic [15:0] rdData,
  input  logic        maskPeriod,
  input  logic        maskMatch,
  output logic        toggleOut,
  output logic        irqPeriod,
  output logic        irqMatch
);
  localparam int CNT_W = 16;

  ivtStrobe_t       stb;
  logic [CNT_W-1:0] countVal;
  logic             eqPeriod;
  logic             eqMatch;

  ivt_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .cntEn      (cntEn),
    .eqPeriod   (eqPeriod),
    .eqMatch    (eqMatch),
    .maskPeriod (maskPeriod),
    .maskMatch  (maskMatch),
    .stb        (stb),
    .irqPeriod  (irqPeriod),
    .irqMatch   (irqMatch)
  );

  ivt_datapath #(.CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .rdSel     (rdSel),
    .rdData    (rdData),
    .countVal  (countVal),
    .eqPeriod  (eqPeriod),
    .eqMatch   (eqMatch),
    .toggleOut (toggleOut)
  );
endmodule

// File: rtl/interval_timer_checker.sv
module interval_timer_checker (
  input logic        clk,
  input logic        rstN,
  input logic        run,
  input logic        cntEn,
  input logic        maskPeriod,
  input logic        maskMatch,
  input logic [15:0] count,
  input logic        toggleOut,
  input logic        irqPeriod,
  input logic        irqMatch
);
  // R8: stopped timer is cleared and silent
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (count == 16'd0 && !toggleOut && !irqPeriod && !irqMatch));

  // R2: no enable, no movement
  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    (run && !cntEn) |=> $stable(count));

  // R3: enabled step either increments or clears
  a_r3_step_or_clear: assert property (@(posedge clk) disable iff (!rstN)
    (run && cntEn) |=> (count == 16'($past(count) + 16'd1) || count == 16'd0));

  // R3: period pulse coincides with a cleared counter
  a_r3_pulse_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    irqPeriod |-> count == 16'd0);

  // R5: match pulse accompanies a pin inversion
  a_r5_pulse_with_flip: assert property (@(posedge clk) disable iff (!rstN)
    irqMatch |-> toggleOut != $past(toggleOut));

  // R9: masks suppress their pulses
  a_r9_mask_match: assert property (@(posedge clk) disable iff (!rstN)
    $past(maskMatch) |-> !irqMatch);
  a_r9_mask_period: assert property (@(posedge clk) disable iff (!rstN)
    $past(maskPeriod) |-> !irqPeriod);
endmodule

bind interval_timer interval_timer_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .run        (run),
  .cntEn      (cntEn),
  .maskPeriod (maskPeriod),
  .maskMatch  (maskMatch),
  .count      (countVal),
  .toggleOut  (toggleOut),
  .irqPeriod  (irqPeriod),
  .irqMatch   (irqMatch)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0, cntEn = 1'b0, wrEn = 1'b0, wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdSel = 2'd0;
  logic        maskPeriod = 1'b0, maskMatch = 1'b0;
  logic [15:0] rdData;
  logic        toggleOut, irqPeriod, irqMatch;

  interval_timer dut (
    .clk(clk), .rstN(rstN), .run(run), .cntEn(cntEn), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .maskPeriod(maskPeriod), .maskMatch(maskMatch),
    .toggleOut(toggleOut), .irqPeriod(irqPeriod), .irqMatch(irqMatch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int mReg[2], mBuf[2], mCount;
  bit mTog, mIrqP, mIrqM;
  int checks = 0, fails = 0;
  bit done = 0;
  string scen = "R1";
  int nIrqP, nIrqM, nFlip;
  bit prevTog;

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", scen, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    int nr[2];
    bit eqM;
    for (int i = 0; i < 2; i++)
      nr[i] = (wrEn && wrSel == i[0]) ? int'(wrData) : mReg[i];
    if (!rstN) begin
      mReg = '{65535, 65535}; mBuf = '{65535, 65535};
      mCount = 0; mTog = 0; mIrqP = 0; mIrqM = 0;
      return;
    end
    mIrqP = 0; mIrqM = 0;
    if (!run) begin
      mCount = 0; mTog = 0; mBuf = nr;
    end else if (cntEn) begin
      eqM = (mCount == mBuf[1]);
      if (eqM) begin mTog = !mTog; mIrqM = !maskMatch; end
      if (mCount == mBuf[0]) begin
        mCount = 0; mIrqP = !maskPeriod; mBuf = nr;
      end else mCount = (mCount + 1) & 16'hFFFF;
    end
    mReg = nr;
  endtask

  function automatic int expRd();
    case (rdSel)
      2'd0: return mReg[0];
      2'd1: return mReg[1];
      2'd2: return mCount;
      default: return 0;
    endcase
  endfunction

  // one clock: model at the edge, compare at the falling edge
  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk(toggleOut == mTog, "toggleOut R5", toggleOut, mTog);
    chk(irqPeriod == mIrqP, "irqPeriod R3", irqPeriod, mIrqP);
    chk(irqMatch == mIrqM, "irqMatch R5", irqMatch, mIrqM);
    chk(int'(rdData) == expRd(), "rdData R7", rdData, expRd());
    nIrqP += irqPeriod; nIrqM += irqMatch;
    nFlip += (toggleOut != prevTog);
    prevTog = toggleOut;
    wrEn = 0;
    rdSel = rdSel + 2'd1;
  endtask

  task automatic writeReg(bit sel, int val);
    wrEn = 1; wrSel = sel; wrData = 16'(val);
    tick();
  endtask

  task automatic clearTally();
    nIrqP = 0; nIrqM = 0; nFlip = 0;
  endtask

  task automatic readCheck(logic [1:0] sel, int exp, string what);
    rdSel = sel; #1;
    chk(int'(rdData) == exp, what, rdData, exp);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    // R1 reset state
    scen = "R1";
    readCheck(2'd0, 16'hFFFF, "R1 period reg");
    readCheck(2'd1, 16'hFFFF, "R1 match reg");
    readCheck(2'd2, 0, "R1 count");
    chk(!toggleOut && !irqPeriod && !irqMatch, "R1 outputs", toggleOut, 0);

    // R3 / R10: period 4, match unused
    scen = "R10";
    writeReg(0, 4); writeReg(1, 16'hFFFF);
    clearTally(); run = 1; cntEn = 1;
    repeat (50) tick();
    chk(nIrqP == 10, "R3 period pulse count", nIrqP, 10);
    chk(nIrqM == 0 && nFlip == 0, "R10 no match activity", nIrqM + nFlip, 0);

    // R2 sparse enable
    scen = "R2"; run = 0; tick(); run = 1;
    clearTally();
    for (int i = 0; i < 60; i++) begin cntEn = (i % 3 == 0); tick(); end
    chk(nIrqP == 4, "R2 sparse period count", nIrqP, 4);

    // R6 square wave
    scen = "R6"; run = 0; cntEn = 1;
    writeReg(0, 4); writeReg(1, 4);
    run = 1; clearTally();
    repeat (50) tick();
    chk(nFlip == 10, "R6 toggle flips", nFlip, 10);
    chk(nIrqM == 10, "R5 match pulses", nIrqM, 10);

    // R4 mid-period write of match register
    scen = "R4"; run = 0; tick();
    writeReg(0, 9); writeReg(1, 16'hFFFF);
    run = 1; repeat (3) tick();
    writeReg(1, 1); clearTally();
    repeat (6) tick();
    chk(nFlip == 0, "R4 no flip before reload", nFlip, 0);
    repeat (10) tick();
    chk(nFlip == 1, "R4 flip after reload", nFlip, 1);

    // R9 masks
    scen = "R9"; maskPeriod = 1; maskMatch = 1; clearTally();
    repeat (40) tick();
    chk(nIrqP == 0 && nIrqM == 0, "R9 masked pulses", nIrqP + nIrqM, 0);
    chk(nFlip == 4, "R9 toggle unaffected", nFlip, 4);
    maskPeriod = 0; maskMatch = 0;

    // R8 stop mid-interval
    scen = "R8"; repeat (3) tick(); run = 0; tick();
    readCheck(2'd2, 0, "R8 count cleared");
    chk(!toggleOut, "R8 toggle low", toggleOut, 0);
    tick();

    // R3 period zero corner
    scen = "R3"; writeReg(0, 0); writeReg(1, 16'hFFFF);
    run = 1; clearTally();
    repeat (20) tick();
    chk(nIrqP == 20, "R3 zero period pulses", nIrqP, 20);

    // random mix
    scen = "R7";
    for (int i = 0; i < 3000; i++) begin
      cntEn = ($urandom % 4) != 0;
      if ($urandom % 40 == 0) begin wrEn = 1; wrSel = $urandom % 2; wrData = 16'($urandom % 12); end
      if ($urandom % 200 == 0) run = !run;
      maskMatch = ($urandom % 8) == 0;
      maskPeriod = ($urandom % 8) == 0;
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule